// File: doc/BRIEF.md
# Binary Conversion Game Controller

This block is the control core of an interactive number game. A 16-bit pseudo-random shift register runs on every clock. At the start of each round the controller takes a sample of it, cuts the sample down to the current difficulty width and presents the result as a 12-bit target. A separate display path shows that target in decimal. The player sets the binary form of the number on twelve switches and presses a submit button. The button is synchronised and debounced. Only a stable press produces a submission, and the switch value is compared with the target at that moment.

A match lights the "correct" indicator for a programmable time. It also widens the difficulty by one bit, so the first rounds draw from 0..15 and the range grows to the full 0..4095. After the hold time the controller starts a new round. A mismatch leaves the indicator dark and keeps the same target, so the player can try again.

All logic runs from one clock (100 MHz in the intended system). The reset input is asynchronous and active-low. It is released synchronously inside the block.

Top module: `bingame_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `correct_o` is 0 and `target_o` is 0. Within a few cycles of release the first round begins with a target below 16.
- R2: The difficulty width starts at 4 bits and grows by one bit on each correct answer, up to 12 bits. Every target lies below 2^width, where width is the value in force when the round started. The shift register is seeded with a nonzero value and never reaches zero.
- R3: `target_o` changes only when a round starts. After a wrong submission, `target_o` keeps its value and `correct_o` stays 0.
- R4: A debounced press while `sw_i` equals `target_o` drives `correct_o` to 1 within DEB_CYCLES+6 cycles of the button going high.
- R5: Once `correct_o` rises it stays at 1 for HOLD_CYCLES cycles. It then returns to 0, and a new target is taken.
- R6: A button high time shorter than DEB_CYCLES cycles causes no submission, even when the switches match.
- R7: Only the stable rising level of the button submits. Releasing the button, or changing the switches while the button is held, causes no submission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_i | input | 12 | Player's binary answer from the switch bank |
| ok_btn_i | input | 1 | Raw, bouncy submit button (high = pressed) |
| target_o | output | 12 | Current target value, for the display path |
| correct_o | output | 1 | Correct-answer indicator |

## Verification
A wrong difficulty width shows at `target_o` from the next round onward. The target either exceeds the bound for the number of wins so far, or it never reaches the upper half of the full range once the width should have reached 12 bits. A bad round state or a bad debounce count shows within one debounce window: a glitch or a release that submits, a matching answer that leaves `correct_o` dark, or a target that moves after a wrong answer. A bad hold counter shows as `correct_o` dropping early or staying lit past the expected window.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_ROUND = 2'd1,
    GS_WAIT  = 2'd2,
    GS_SHOW  = 2'd3
  } game_state_e;
endpackage

// File: rtl/bg_debounce.sv
module bg_debounce #(
  parameter int unsigned DEB_CYCLES = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic press_o
);
  localparam int unsigned CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic meta_q, sync_q, level_q, level_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic press_q, press_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    press_d = 1'b0;
    if (sync_q != level_q) begin
      if (cnt_q == CNT_LAST) begin
        level_d = sync_q;
        press_d = sync_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
      press_q <= press_d;
    end
  end

  assign press_o = press_q;

  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_q |=> !press_q);

  // R6
  press_needs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_q |-> level_q);
endmodule

// File: rtl/bg_lfsr.sv
module bg_lfsr #(
  parameter int unsigned  LFSR_W = 16,
  parameter logic [15:0]  SEED   = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] q, d;
  logic fb;

  generate
    if (LFSR_W == 16) begin : g_w16
      assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];
    end else begin : g_wother
      assign fb = q[LFSR_W-1] ^ q[LFSR_W-2];
    end
  endgenerate

  always_comb begin
    d = q;
    if (step_i) d = {q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= LFSR_W'(SEED);
    else         q <= d;
  end

  assign state_o = q;

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);
endmodule

// File: rtl/bg_fsm.sv
module bg_fsm
  import bg_pkg::*;
#(
  parameter int unsigned VAL_W       = 12,
  parameter int unsigned MIN_W       = 4,
  parameter int unsigned RAND_W      = 16,
  parameter int unsigned HOLD_CYCLES = 50_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              press_i,
  input  logic [VAL_W-1:0]  sw_i,
  input  logic [RAND_W-1:0] rand_i,
  output logic [VAL_W-1:0]  target_o,
  output logic              correct_o
);
  localparam int unsigned LVL_W  = $clog2(VAL_W + 1);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [LVL_W-1:0]  LVL_MIN   = LVL_W'(MIN_W);
  localparam logic [LVL_W-1:0]  LVL_MAX   = LVL_W'(VAL_W);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  game_state_e       state_q, state_d;
  logic [VAL_W-1:0]  target_q, target_d;
  logic [LVL_W-1:0]  width_q, width_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              correct_q, correct_d;
  logic [VAL_W-1:0]  mask;

  always_comb begin
    for (int i = 0; i < int'(VAL_W); i++) begin
      mask[i] = (i < int'(width_q));
    end
  end

  always_comb begin
    state_d   = state_q;
    target_d  = target_q;
    width_d   = width_q;
    hold_d    = hold_q;
    correct_d = correct_q;
    unique case (state_q)
      GS_IDLE: state_d = GS_ROUND;
      GS_ROUND: begin
        target_d  = rand_i[VAL_W-1:0] & mask;
        correct_d = 1'b0;
        state_d   = GS_WAIT;
      end
      GS_WAIT: begin
        if (press_i) begin
          if (sw_i == target_q) begin
            correct_d = 1'b1;
            hold_d    = '0;
            state_d   = GS_SHOW;
            if (width_q < LVL_MAX) width_d = width_q + 1'b1;
          end else begin
            correct_d = 1'b0;
          end
        end
      end
      GS_SHOW: begin
        if (hold_q == HOLD_LAST) begin
          correct_d = 1'b0;
          state_d   = GS_ROUND;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
      default: state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= GS_IDLE;
      target_q  <= '0;
      width_q   <= LVL_MIN;
      hold_q    <= '0;
      correct_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      target_q  <= target_d;
      width_q   <= width_d;
      hold_q    <= hold_d;
      correct_q <= correct_d;
    end
  end

  assign target_o  = target_q;
  assign correct_o = correct_q;

  // R2
  target_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_q & ~mask) == '0);

  // R2
  width_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_q >= LVL_MIN) && (width_q <= LVL_MAX));

  // R3
  target_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != GS_ROUND) |=> $stable(target_q));

  // R4
  correct_after_press_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(correct_q) |-> $past(press_i));

  // R5
  correct_ends_round_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(correct_q) |-> state_q == GS_ROUND);
endmodule

// File: rtl/bingame_ctrl.sv
module bingame_ctrl #(
  parameter int unsigned VAL_W       = 12,
  parameter int unsigned MIN_W       = 4,
  parameter int unsigned RAND_W      = 16,
  parameter logic [15:0] RAND_SEED   = 16'hACE1,
  parameter int unsigned DEB_CYCLES  = 1_000_000,
  parameter int unsigned HOLD_CYCLES = 50_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VAL_W-1:0] sw_i,
  input  logic             ok_btn_i,
  output logic [VAL_W-1:0] target_o,
  output logic             correct_o
);
  logic rst_meta_q, rst_sync_q;
  logic press;
  logic [RAND_W-1:0] rand_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bg_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_debounce (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .raw_i   (ok_btn_i),
    .press_o (press)
  );

  bg_lfsr #(.LFSR_W(RAND_W), .SEED(RAND_SEED)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .step_i  (1'b1),
    .state_o (rand_state)
  );

  bg_fsm #(
    .VAL_W       (VAL_W),
    .MIN_W       (MIN_W),
    .RAND_W      (RAND_W),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .press_i   (press),
    .sw_i      (sw_i),
    .rand_i    (rand_state),
    .target_o  (target_o),
    .correct_o (correct_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_sync_q |-> (!correct_o && target_o == '0));
endmodule

// File: tb/test_bingame_ctrl.sv
module test_bingame_ctrl;
  localparam int DEB  = 8;
  localparam int HOLD = 60;

  logic        clk;
  logic        rst_n;
  logic [11:0] sw;
  logic        btn;
  logic [11:0] target;
  logic        correct;

  int n_vec = 0;
  int n_bad = 0;
  int wins  = 0;
  bit done  = 0;

  bingame_ctrl #(.DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) i_bingame_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sw_i      (sw),
    .ok_btn_i  (btn),
    .target_o  (target),
    .correct_o (correct)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bound_now();
    int w;
    w = 4 + wins;
    if (w > 12) w = 12;
    return 1 << w;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; sw = '0; btn = 1'b0;
    cyc(4);
    chk(correct == 1'b0, "R1 correct in reset", int'(correct), 0);
    chk(target == 12'd0, "R1 target in reset", int'(target), 0);
    rst_n = 1'b1;
    cyc(8);
    chk(correct == 1'b0, "R1 correct after reset", int'(correct), 0);
    chk(int'(target) < 16, "R1 first target below 16", int'(target), 15);
  endtask

  task automatic t_wrong();
    logic [11:0] t0;
    t0 = target;
    sw = t0 ^ 12'h001;
    btn = 1'b1; cyc(DEB + 12); btn = 1'b0; cyc(DEB + 12);
    chk(correct == 1'b0, "R3 wrong answer keeps LED dark", int'(correct), 0);
    chk(target == t0, "R3 wrong answer keeps target", int'(target), int'(t0));
  endtask

  task automatic t_glitch();
    logic [11:0] t0;
    t0 = target;
    sw = t0;
    for (int k = 0; k < 3; k++) begin
      btn = 1'b1; cyc(DEB - 3); btn = 1'b0; cyc(4);
    end
    cyc(DEB + 10);
    chk(correct == 1'b0, "R6 short pulse ignored", int'(correct), 0);
    chk(target == t0, "R6 target after short pulse", int'(target), int'(t0));
  endtask

  task automatic t_release();
    logic [11:0] t0;
    t0 = target;
    sw = t0 ^ 12'h002;
    btn = 1'b1; cyc(DEB + 12);
    sw = t0;
    cyc(DEB + 6);
    btn = 1'b0; cyc(DEB + 20);
    chk(correct == 1'b0, "R7 held or released button does not submit", int'(correct), 0);
    chk(target == t0, "R7 target unchanged", int'(target), int'(t0));
  endtask

  task automatic t_win(output int newt);
    logic [11:0] t0;
    t0 = target;
    sw = t0;
    btn = 1'b1;
    cyc(20);
    chk(correct == 1'b1, "R4 matching press lights LED", int'(correct), 1);
    btn = 1'b0;
    cyc(40);
    chk(correct == 1'b1, "R5 LED held during hold time", int'(correct), 1);
    wins++;
    cyc(30);
    chk(correct == 1'b0, "R5 LED cleared after hold time", int'(correct), 0);
    chk(int'(target) < bound_now(), "R2 target within widened range",
        int'(target), bound_now() - 1);
    newt = int'(target);
  endtask

  initial begin
    int nt;
    int maxt;
    maxt = 0;
    t_reset();
    t_wrong();
    t_glitch();
    t_release();
    for (int r = 0; r < 20; r++) begin
      t_win(nt);
      if (wins >= 8 && nt > maxt) maxt = nt;
    end
    t_wrong();
    chk(maxt >= 2048, "R2 range reaches 12 bits", maxt, 2048);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule